// File: doc/BRIEF.md
# Write-Once Snooping Data Cache

This block is a small direct-mapped, write-back data cache for one processor on a shared bus that other masters also use. Each line holds a single word, its tag and one of four coherence states: Invalid, Valid (clean, possibly held elsewhere), Reserved (clean, written once, sole cached copy) or Dirty (modified, sole copy). The first store to a clean shared line is sent to memory as well, so that the other caches see a bus write and drop their copies. Later stores to the same line stay local.

The processor side is a request/ready handshake. The processor holds `cpu_req` and its operands stable until `cpu_ready` pulses for one cycle, with load data on `cpu_rdata`. The bus side is a master port that holds a request until memory returns a one-cycle acknowledge. A snoop input reports the reads and writes that other masters place on the bus. When such an access hits a modified line, `snp_abort` tells the other master to back off until the line has been written to memory. Snoops are looked at only while the controller is idle. The system keeps other masters off the bus while this block owns it, so snoops arrive only then.

Top module: `wonce_cache`

## Requirements
- R1: After reset every line is Invalid and `cpu_ready`, `bus_req` and `snp_abort` are low, so the first access to any address misses.
- R2: A load miss issues one bus read (`bus_we`=0) of the requested address, fills the line in Valid and returns the word that memory supplied. The bus address, direction and data stay unchanged while a request waits for its acknowledge.
- R3: A load hit in Valid, Reserved or Dirty makes no bus access, returns the cached word with `cpu_ready` in the cycle after the request is taken, and leaves the state unchanged. `cpu_ready` is never high for two cycles in a row.
- R4: A store hit on a Valid line updates the cached word, makes exactly one bus write of that word to that address, and leaves the line Reserved.
- R5: A store hit on a Reserved or Dirty line updates only the cached word, makes no bus access and leaves the line Dirty.
- R6: A store miss makes one bus write of the store data to the store address and allocates the line with that data in Reserved.
- R7: A snooped read that hits a Valid line changes nothing. One that hits a Reserved line moves it to Valid. A snooped access that misses changes nothing. None of these raises `snp_abort`.
- R8: A snooped write that hits a Valid or Reserved line moves it to Invalid, with no abort and no bus access.
- R9: A snooped access that hits a Dirty line raises `snp_abort` from the next cycle. The cache writes the line's word back to its own address, keeps `snp_abort` high with the write pending until the acknowledge, and then leaves the line Valid after a read or Invalid after a write.
- R10: A miss whose line holds Dirty data under another tag first writes the old word back to the old address, then makes its own read or write. A Valid or Reserved victim is dropped with no bus access.
- R11: A snoop presented in the same cycle as a processor request is handled first, and the request then sees the updated line state. `cpu_ready` is never high while `bus_req` or `snp_abort` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request, held until `bus_ack` |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data, valid with `bus_ack` |
| bus_ack | input | 1 | One-cycle completion from memory |
| snp_valid | input | 1 | Another master's access is on the bus |
| snp_we | input | 1 | Snooped access is a write |
| snp_addr | input | ADDR_W | Snooped word address |
| snp_abort | output | 1 | Tells the snooped master to retry later |

## Verification
Each line is walked through every state in turn. Load and store hits are run on Valid, Reserved and Dirty lines, and the bus traffic that each one causes (a write-through, or none) shows which state the line was in. Misses are run against Invalid, clean and modified victims, which separates a silent drop from a write-back that must come before the fill or allocate. Snooped reads and writes are sent at lines in each state and at unmatched tags, and a later processor access exposes the state that each snoop left behind. Snoops that arrive in the same cycle as a processor request to the same line check that the snoop is served first.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_VAL = 2'd1,
    LS_RSV = 2'd2,
    LS_DRT = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    C_IDLE,
    C_VWB,
    C_FILL,
    C_WT,
    C_SWB
  } ctl_st_e;
endpackage

// File: rtl/wc_tag_match.sv
module wc_tag_match #(
  parameter int TAG_W = 6
) (
  input  wc_pkg::line_st_e   st,
  input  logic [TAG_W-1:0]   line_tag,
  input  logic [TAG_W-1:0]   look_tag,
  output logic               hit
);
  assign hit = (st != wc_pkg::LS_INV) && (line_tag == look_tag);
endmodule

// File: rtl/wc_line_store.sv
module wc_line_store #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IDX_W-1:0]    ra_idx,
  output wc_pkg::line_st_e    ra_st,
  output logic [TAG_W-1:0]    ra_tag,
  output logic [DATA_W-1:0]   ra_data,
  input  logic [IDX_W-1:0]    rb_idx,
  output wc_pkg::line_st_e    rb_st,
  output logic [TAG_W-1:0]    rb_tag,
  output logic [DATA_W-1:0]   rb_data,
  input  logic                wr_en,
  input  logic                wr_den,
  input  logic [IDX_W-1:0]    wr_idx,
  input  wc_pkg::line_st_e    wr_st,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [DATA_W-1:0]   wr_data
);
  wc_pkg::line_st_e    st_q  [LINES];
  logic [TAG_W-1:0]    tag_q [LINES];
  logic [DATA_W-1:0]   dat_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= wc_pkg::LS_INV;
    end else if (wr_en) begin
      st_q[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_den) begin
      tag_q[wr_idx] <= wr_tag;
      dat_q[wr_idx] <= wr_data;
    end
  end

  assign ra_st   = st_q[ra_idx];
  assign ra_tag  = tag_q[ra_idx];
  assign ra_data = dat_q[ra_idx];
  assign rb_st   = st_q[rb_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rb_data = dat_q[rb_idx];
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_ready,
  output logic                bus_req,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_ack,
  input  logic                snp_valid,
  input  logic                snp_we,
  input  logic [IDX_W-1:0]    snp_idx,
  output logic                snp_abort,
  input  logic                hit_a,
  input  wc_pkg::line_st_e    st_a,
  input  logic [TAG_W-1:0]    tag_a,
  input  logic [DATA_W-1:0]   data_a,
  input  logic                hit_b,
  input  wc_pkg::line_st_e    st_b,
  input  logic [TAG_W-1:0]    tag_b,
  input  logic [DATA_W-1:0]   data_b,
  output logic                lw_en,
  output logic                lw_den,
  output logic [IDX_W-1:0]    lw_idx,
  output wc_pkg::line_st_e    lw_st,
  output logic [TAG_W-1:0]    lw_tag,
  output logic [DATA_W-1:0]   lw_data
);
  import wc_pkg::*;

  ctl_st_e             cs_q, cs_n;
  logic                breq_n, bwe_n, abort_n, rdy_n, swe_q, swe_n, start_miss;
  logic [ADDR_W-1:0]   badr_n;
  logic [DATA_W-1:0]   bwd_n, rdat_n;
  logic [IDX_W-1:0]    sidx_q, sidx_n;
  logic [IDX_W-1:0]    cpu_idx;

  assign cpu_idx = cpu_addr[IDX_W-1:0];

  always_comb begin
    cs_n = cs_q;  breq_n = bus_req;  bwe_n = bus_we;  badr_n = bus_addr;
    bwd_n = bus_wdata;  abort_n = snp_abort;  rdy_n = 1'b0;  rdat_n = cpu_rdata;
    swe_n = swe_q;  sidx_n = sidx_q;  start_miss = 1'b0;
    lw_en = 1'b0;  lw_den = 1'b0;  lw_idx = cpu_idx;  lw_st = LS_INV;
    lw_tag = cpu_addr[ADDR_W-1:IDX_W];  lw_data = cpu_wdata;
    case (cs_q)
      C_IDLE: begin
        if (snp_valid) begin
          if (hit_b) begin
            lw_idx = snp_idx;
            case (st_b)
              LS_DRT: begin
                cs_n = C_SWB;  abort_n = 1'b1;  breq_n = 1'b1;  bwe_n = 1'b1;
                badr_n = {tag_b, snp_idx};  bwd_n = data_b;
                swe_n = snp_we;  sidx_n = snp_idx;
              end
              LS_RSV: begin
                lw_en = 1'b1;  lw_st = snp_we ? LS_INV : LS_VAL;
              end
              default: begin
                lw_en = snp_we;  lw_st = LS_INV;
              end
            endcase
          end
        end else if (cpu_req && !cpu_ready) begin
          if (hit_a) begin
            if (!cpu_we) begin
              rdy_n = 1'b1;  rdat_n = data_a;
            end else begin
              lw_en = 1'b1;  lw_den = 1'b1;
              if (st_a == LS_VAL) begin
                lw_st = LS_RSV;  cs_n = C_WT;  breq_n = 1'b1;  bwe_n = 1'b1;
                badr_n = cpu_addr;  bwd_n = cpu_wdata;
              end else begin
                lw_st = LS_DRT;  rdy_n = 1'b1;
              end
            end
          end else if (st_a == LS_DRT) begin
            cs_n = C_VWB;  breq_n = 1'b1;  bwe_n = 1'b1;
            badr_n = {tag_a, cpu_idx};  bwd_n = data_a;
          end else begin
            start_miss = 1'b1;
          end
        end
      end
      C_VWB: start_miss = bus_ack;
      C_FILL: if (bus_ack) begin
        lw_en = 1'b1;  lw_den = 1'b1;  lw_st = LS_VAL;  lw_data = bus_rdata;
        rdat_n = bus_rdata;  rdy_n = 1'b1;  breq_n = 1'b0;  cs_n = C_IDLE;
      end
      C_WT: if (bus_ack) begin
        rdy_n = 1'b1;  breq_n = 1'b0;  cs_n = C_IDLE;
      end
      C_SWB: if (bus_ack) begin
        lw_en = 1'b1;  lw_idx = sidx_q;  lw_st = swe_q ? LS_INV : LS_VAL;
        abort_n = 1'b0;  breq_n = 1'b0;  cs_n = C_IDLE;
      end
      default: cs_n = C_IDLE;
    endcase
    if (start_miss) begin
      breq_n = 1'b1;  badr_n = cpu_addr;
      if (cpu_we) begin
        cs_n = C_WT;  bwe_n = 1'b1;  bwd_n = cpu_wdata;
        lw_en = 1'b1;  lw_den = 1'b1;  lw_st = LS_RSV;
      end else begin
        cs_n = C_FILL;  bwe_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= C_IDLE;  bus_req <= 1'b0;  bus_we <= 1'b0;  bus_addr <= '0;
      bus_wdata <= '0;  snp_abort <= 1'b0;  cpu_ready <= 1'b0;  cpu_rdata <= '0;
      swe_q <= 1'b0;  sidx_q <= '0;
    end else begin
      cs_q <= cs_n;  bus_req <= breq_n;  bus_we <= bwe_n;  bus_addr <= badr_n;
      bus_wdata <= bwd_n;  snp_abort <= abort_n;  cpu_ready <= rdy_n;
      cpu_rdata <= rdat_n;  swe_q <= swe_n;  sidx_q <= sidx_n;
    end
  end
endmodule

// File: rtl/wonce_cache.sv
module wonce_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_ready,
  output logic                bus_req,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                bus_ack,
  input  logic                snp_valid,
  input  logic                snp_we,
  input  logic [ADDR_W-1:0]   snp_addr,
  output logic                snp_abort
);
  wc_pkg::line_st_e   st_a, st_b, lw_st;
  logic [TAG_W-1:0]   tag_a, tag_b, lw_tag;
  logic [DATA_W-1:0]  data_a, data_b, lw_data;
  logic               hit_a, hit_b, lw_en, lw_den;
  logic [IDX_W-1:0]   lw_idx;

  wc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .ra_idx(cpu_addr[IDX_W-1:0]), .ra_st(st_a), .ra_tag(tag_a), .ra_data(data_a),
    .rb_idx(snp_addr[IDX_W-1:0]), .rb_st(st_b), .rb_tag(tag_b), .rb_data(data_b),
    .wr_en(lw_en), .wr_den(lw_den), .wr_idx(lw_idx), .wr_st(lw_st),
    .wr_tag(lw_tag), .wr_data(lw_data)
  );

  wc_tag_match #(.TAG_W(TAG_W)) u_match_cpu (
    .st(st_a), .line_tag(tag_a), .look_tag(cpu_addr[ADDR_W-1:IDX_W]), .hit(hit_a)
  );

  wc_tag_match #(.TAG_W(TAG_W)) u_match_snp (
    .st(st_b), .line_tag(tag_b), .look_tag(snp_addr[ADDR_W-1:IDX_W]), .hit(hit_b)
  );

  wc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .snp_valid(snp_valid), .snp_we(snp_we), .snp_idx(snp_addr[IDX_W-1:0]),
    .snp_abort(snp_abort),
    .hit_a(hit_a), .st_a(st_a), .tag_a(tag_a), .data_a(data_a),
    .hit_b(hit_b), .st_b(st_b), .tag_b(tag_b), .data_b(data_b),
    .lw_en(lw_en), .lw_den(lw_den), .lw_idx(lw_idx), .lw_st(lw_st),
    .lw_tag(lw_tag), .lw_data(lw_data)
  );
endmodule

// File: rtl/wonce_cache_chk.sv
module wonce_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                cpu_ready,
  input logic                bus_req,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic                bus_ack,
  input logic                snp_abort
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!bus_req && !cpu_ready && !snp_abort)); // R1

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R2

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R3

  AST_ABORT_HELD: assert property (@(posedge clk) disable iff (rst)
    (snp_abort && !bus_ack) |=> snp_abort); // R9

  AST_ABORT_WRITES: assert property (@(posedge clk) disable iff (rst)
    snp_abort |-> (bus_req && bus_we)); // R9

  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> (!bus_req && !snp_abort)); // R11
endmodule

bind wonce_cache wonce_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .snp_abort(snp_abort)
);

// File: tb/test_wonce_cache.sv
`timescale 1ns/1ps
module test_wonce_cache;
  localparam int AW = 8, DW = 16, NL = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_req = 0, cpu_we = 0, cpu_ready, bus_req, bus_we, bus_ack = 0;
  logic snp_valid = 0, snp_we = 0, snp_abort;
  logic [AW-1:0] cpu_addr = 0, bus_addr, snp_addr = 0;
  logic [DW-1:0] cpu_wdata = 0, cpu_rdata, bus_wdata, bus_rdata = 0;

  wonce_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) i_wonce_cache (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, ready_busy = 0, cnt = 0;
  logic [DW-1:0] mem [256];
  logic [AW+DW:0] log_q [$];
  logic [AW+DW:0] exp_q [$];
  int mst [NL];
  int mtag [NL];
  logic [DW-1:0] mdat [NL];

  // memory with two-cycle latency; logs each completed transfer
  always @(negedge clk) begin
    if (rst || bus_ack) begin
      bus_ack <= 1'b0; cnt = 0;
    end else if (bus_req) begin
      if (cnt == 1) begin
        bus_ack <= 1'b1;
        if (bus_we) mem[bus_addr] = bus_wdata;
        else bus_rdata <= mem[bus_addr];
        log_q.push_back({bus_we, bus_addr, bus_we ? bus_wdata : 16'h0});
      end else cnt++;
    end
    if (!rst && cpu_ready && (bus_req || snp_abort)) ready_busy++;
  end

  task automatic chk(input bit ok, input string rq, input string what, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %s expected %s", rq, what, act, exp);
    end
  endtask

  task automatic chk_log(input string rq, input string what);
    bit ok = (log_q.size() == exp_q.size());
    if (ok) foreach (exp_q[i]) if (log_q[i] !== exp_q[i]) ok = 0;
    chk(ok, rq, what, $sformatf("%p", log_q), $sformatf("%p", exp_q));
  endtask

  // reference: states 0=I 1=V 2=R 3=D
  task automatic model_snoop(input bit we, input logic [AW-1:0] a, output bit ab);
    int idx = a % NL, tg = a / NL;
    ab = 0;
    if (mst[idx] != 0 && mtag[idx] == tg) begin
      if (mst[idx] == 3) begin
        ab = 1; exp_q.push_back({1'b1, a, mdat[idx]});
        mst[idx] = we ? 0 : 1;
      end else if (we) mst[idx] = 0;
      else mst[idx] = 1;
    end
  endtask

  task automatic model_cpu(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           output logic [DW-1:0] rd, output bit hit);
    int idx = a % NL, tg = a / NL;
    rd = 'x;
    hit = (mst[idx] != 0 && mtag[idx] == tg);
    if (hit) begin
      if (!we) rd = mdat[idx];
      else begin
        mdat[idx] = d;
        if (mst[idx] == 1) begin exp_q.push_back({1'b1, a, d}); mst[idx] = 2; end
        else mst[idx] = 3;
      end
    end else begin
      if (mst[idx] == 3)
        exp_q.push_back({1'b1, AW'(mtag[idx] * NL + idx), mdat[idx]});
      mtag[idx] = tg;
      if (we) begin
        exp_q.push_back({1'b1, a, d}); mst[idx] = 2; mdat[idx] = d;
      end else begin
        exp_q.push_back({1'b0, a, 16'h0}); mst[idx] = 1; mdat[idx] = mem[a];
        rd = mem[a];
      end
    end
  endtask

  task automatic cpu_op(input string rq, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit with_snp = 0, input bit swe = 0, input logic [AW-1:0] sa = 0);
    logic [DW-1:0] erd; bit hit, ab; int n = 0;
    exp_q.delete(); log_q.delete();
    if (with_snp) model_snoop(swe, sa, ab);
    model_cpu(we, a, d, erd, hit);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    snp_valid = with_snp; snp_we = swe; snp_addr = sa;
    do begin @(negedge clk); snp_valid = 0; n++; end while (!cpu_ready && n < 100);
    cpu_req = 0;
    chk(cpu_ready, rq, "ready seen", $sformatf("%0d", cpu_ready), "1");
    if (!we) chk(cpu_rdata === erd, rq, $sformatf("rdata @%h", a), $sformatf("%h", cpu_rdata), $sformatf("%h", erd));
    if (!we && hit && !with_snp) chk(n == 1, rq, "hit latency", $sformatf("%0d", n), "1");
    chk_log(rq, $sformatf("bus traffic op we=%0d @%h", we, a));
    @(negedge clk);
  endtask

  task automatic snoop(input string rq, input bit we, input logic [AW-1:0] a);
    bit ab; int n = 0;
    exp_q.delete(); log_q.delete();
    model_snoop(we, a, ab);
    snp_valid = 1; snp_we = we; snp_addr = a;
    @(negedge clk); snp_valid = 0;
    chk(snp_abort === ab, rq, $sformatf("abort on snoop we=%0d @%h", we, a), $sformatf("%0d", snp_abort), $sformatf("%0d", ab));
    while (snp_abort && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    chk_log(rq, $sformatf("bus traffic snoop we=%0d @%h", we, a));
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
    for (int i = 0; i < NL; i++) begin mst[i] = 0; mtag[i] = 0; mdat[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!cpu_ready && !bus_req && !snp_abort, "R1", "outputs after reset",
        $sformatf("%b%b%b", cpu_ready, bus_req, snp_abort), "000");
    cpu_op("R1_R2", 0, 8'h10, 0);          // cold miss, fill Valid
    cpu_op("R3", 0, 8'h10, 0);             // load hit Valid
    cpu_op("R4", 1, 8'h10, 16'hA1A1);      // write-through, Reserved
    cpu_op("R5", 1, 8'h10, 16'hB2B2);      // Reserved -> Dirty, local
    cpu_op("R5", 1, 8'h10, 16'hC3C3);      // Dirty stays local
    cpu_op("R3", 0, 8'h10, 0);             // load hit Dirty
    cpu_op("R10", 0, 8'h14, 0);            // dirty victim written back first
    cpu_op("R10", 0, 8'h10, 0);            // Valid victim dropped, data from memory
    cpu_op("R6", 1, 8'h21, 16'h5151);      // store miss allocate Reserved
    cpu_op("R6", 0, 8'h21, 0);             // hit on Reserved, no bus
    snoop("R7", 0, 8'h21);                 // Reserved -> Valid
    cpu_op("R7", 1, 8'h21, 16'h6161);      // write-through proves Valid
    snoop("R8", 1, 8'h21);                 // Reserved -> Invalid
    cpu_op("R8", 0, 8'h21, 0);             // miss again
    snoop("R7", 0, 8'h21);                 // Valid unchanged
    cpu_op("R7", 0, 8'h21, 0);             // still hit
    snoop("R8", 1, 8'h21);                 // Valid -> Invalid
    cpu_op("R8", 0, 8'h21, 0);
    cpu_op("R6", 1, 8'h22, 16'h7272);
    cpu_op("R5", 1, 8'h22, 16'h8383);
    snoop("R9", 0, 8'h22);                 // dirty: abort + write-back
    cpu_op("R9", 0, 8'h22, 0);             // Valid hit
    cpu_op("R9", 1, 8'h22, 16'h9494);      // write-through proves Valid
    cpu_op("R5", 1, 8'h22, 16'hA5A5);
    snoop("R9", 1, 8'h22);                 // dirty: abort + write-back, Invalid
    cpu_op("R9", 0, 8'h22, 0);             // miss returns written-back word
    snoop("R7_R8", 1, 8'h32);              // tag mismatch, nothing
    cpu_op("R7_R8", 0, 8'h22, 0);
    cpu_op("R2", 0, 8'h13, 0);
    cpu_op("R11", 0, 8'h13, 0, 1, 1, 8'h13);    // snoop write first, then miss
    cpu_op("R6", 1, 8'h13, 16'h1234);
    cpu_op("R5", 1, 8'h13, 16'h4321);
    cpu_op("R11", 0, 8'h13, 0, 1, 0, 8'h13);    // abort/write-back, then hit
    cpu_op("R5", 1, 8'h17, 16'h0F0F);           // miss: Valid victim dropped
    cpu_op("R5", 1, 8'h17, 16'hF0F0);
    cpu_op("R10", 1, 8'h1B, 16'h3C3C);          // store miss with dirty victim
    chk(ready_busy == 0, "R11", "ready while busy cycles", $sformatf("%0d", ready_busy), "0");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule